// File: doc/BRIEF.md
# Threshold Trigger Detector

This block watches a stream of 8-bit digitized samples of an analog signal and raises a trigger when the signal meets one of five conditions. Each condition is set by a pair of programmable thresholds. The sample codes are offset binary: 0x00 stands for the most negative voltage, 0x80 for zero, and 0xFF for the most positive voltage. The thresholds use the same scale, so every comparison is a plain unsigned compare.

There are three stateless conditions: below the low threshold, above the high threshold, and inside the window between the two thresholds. There are also two hysteresis conditions. In these, one threshold arms the trigger and the other releases it, so a noisy input near a single level does not chatter.

The block gives two outputs: a trigger level, and a one-cycle pulse each time that level rises. It only looks at samples marked valid. Disabling the block, or changing the condition, drops the trigger and clears any hysteresis state.

Top module: `thr_trigger_top`

## Requirements
- R1: Sample and thresholds are compared as unsigned offset-binary codes. The condition select encoding is: 0 below, 1 above, 2 window, 3 high-hysteresis, 4 low-hysteresis. Codes 5 to 7 keep the trigger level low.
- R2: In mode 0, a valid sample sets the trigger level to 1 on the next clock edge if the sample is strictly less than the low threshold. Otherwise it sets the level to 0.
- R3: In mode 1, a valid sample sets the level to 1 if the sample is strictly greater than the high threshold. Otherwise it sets the level to 0. The low threshold has no effect in this mode.
- R4: In mode 2, a valid sample sets the level to 1 if low threshold <= sample <= high threshold (both bounds inclusive). Otherwise it sets the level to 0.
- R5: In mode 3, a low level goes high on a valid sample above the high threshold. A high level goes low only on a valid sample below the low threshold; any other valid sample keeps it high.
- R6: In mode 4, a low level goes high on a valid sample below the low threshold. A high level goes low only on a valid sample above the high threshold; any other valid sample keeps it high.
- R7: A cycle with the valid strobe low leaves the trigger level unchanged.
- R8: With the enable low, the trigger level is 0 after the next clock edge, whatever the sample.
- R9: On a clock edge where the condition select differs from its value in the previous cycle, the level is forced to 0. This applies even when a valid sample in that cycle would have set it.
- R10: The trigger pulse is high for exactly the one cycle in which the trigger level first reads 1 after reading 0. It is never high at any other time.
- R11: While reset is held, the trigger level and the trigger pulse are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Detector enable |
| cond_sel | input | 3 | Condition select (R1 encoding) |
| thr_low | input | 8 | Low threshold code |
| thr_high | input | 8 | High threshold code |
| sample | input | 8 | Offset-binary sample code |
| sample_vld | input | 1 | Sample valid strobe |
| trig_level | output | 1 | Trigger level |
| trig_pulse | output | 1 | One-cycle pulse on a rising trigger level |

## Verification
A change of the condition select can land in the same cycle as a valid sample that would set the trigger under the new condition. The clear must win: the level stays low, no pulse appears, and the very next valid sample is judged under the new condition. The bench sets this up on purpose. It holds a sample that satisfies the next condition, then switches the select with the strobe high. It checks the level and pulse right after that edge, and again one sample later.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic [2:0] {
      COND_BELOW  = 3'd0,
      COND_ABOVE  = 3'd1,
      COND_WINDOW = 3'd2,
      COND_HHYST  = 3'd3,
      COND_LHYST  = 3'd4
   } cond_e;
endpackage

// File: rtl/trig_compare.sv
module trig_compare #(
   parameter int DW       = 8,
   parameter bit WIN_INCL = 1'b1
) (
   input  logic [DW-1:0] smp,
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   output logic          below_lo,
   output logic          above_hi,
   output logic          in_win
);
   assign below_lo = smp < lo;
   assign above_hi = smp > hi;
   generate
      if (WIN_INCL) begin : g_incl
         assign in_win = (smp >= lo) && (smp <= hi);
      end else begin : g_excl
         assign in_win = (smp > lo) && (smp < hi);
      end
   endgenerate
endmodule

// File: rtl/trig_state.sv
module trig_state
   import trig_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [2:0] cond,
   input  logic       vld,
   input  logic       below_lo,
   input  logic       above_hi,
   input  logic       in_win,
   output logic       lvl_q,
   output logic       lvl_nxt
);
   logic [2:0] cond_q;
   logic       cond_chg;
   logic       cand;

   assign cond_chg = cond != cond_q;

   always_comb begin
      case (cond)
         COND_BELOW:  cand = below_lo;
         COND_ABOVE:  cand = above_hi;
         COND_WINDOW: cand = in_win;
         COND_HHYST:  cand = lvl_q ? !below_lo : above_hi;
         COND_LHYST:  cand = lvl_q ? !above_hi : below_lo;
         default:     cand = 1'b0;
      endcase
   end

   always_comb begin
      lvl_nxt = lvl_q;
      if (!en || cond_chg) lvl_nxt = 1'b0;
      else if (vld)        lvl_nxt = cand;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         cond_q <= 3'd0;
      end else begin
         lvl_q  <= lvl_nxt;
         cond_q <= cond;
      end
   end

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !vld && !cond_chg) |=> $stable(lvl_q));
   assert_disable_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !lvl_q);
   assert_sel_change_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cond_chg |=> !lvl_q);
   assert_above_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && vld && !cond_chg && cond == COND_ABOVE && above_hi) |=> lvl_q);
   assert_hhyst_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && vld && !cond_chg && cond == COND_HHYST && lvl_q && !below_lo) |=> lvl_q);
   assert_spare_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cond > 3'd4) |=> !lvl_q);
endmodule

// File: rtl/trig_edge.sv
module trig_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cur,
   input  logic nxt,
   output logic pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= nxt & ~cur;
   end

   assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);
endmodule

// File: rtl/thr_trigger_top.sv
module thr_trigger_top #(
   parameter int DW       = 8,
   parameter bit WIN_INCL = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic [2:0]    cond_sel,
   input  logic [DW-1:0] thr_low,
   input  logic [DW-1:0] thr_high,
   input  logic [DW-1:0] sample,
   input  logic          sample_vld,
   output logic          trig_level,
   output logic          trig_pulse
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("thr_trigger_top: DW must be at least 2");
      end
   endgenerate

   logic below_lo, above_hi, in_win, lvl_nxt;

   trig_compare #(.DW(DW), .WIN_INCL(WIN_INCL)) u_cmp (
      .smp(sample), .lo(thr_low), .hi(thr_high),
      .below_lo(below_lo), .above_hi(above_hi), .in_win(in_win)
   );

   trig_state u_state (
      .clk(clk), .rst_n(rst_n), .en(enable), .cond(cond_sel), .vld(sample_vld),
      .below_lo(below_lo), .above_hi(above_hi), .in_win(in_win),
      .lvl_q(trig_level), .lvl_nxt(lvl_nxt)
   );

   trig_edge u_edge (
      .clk(clk), .rst_n(rst_n), .cur(trig_level), .nxt(lvl_nxt), .pulse(trig_pulse)
   );

   assert_pulse_with_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      trig_pulse |-> (trig_level && !$past(trig_level)));
   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |=> (!trig_level && !trig_pulse));
endmodule

// File: tb/thr_trigger_top_bench.sv
`timescale 1ns/1ps
module thr_trigger_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [2:0] cond_sel = 3'd0;
   logic [7:0] thr_low = 8'd0, thr_high = 8'd0, sample = 8'd0;
   logic       sample_vld = 1'b0;
   logic       trig_level, trig_pulse;

   int checks = 0, errors = 0;
   logic exp_lvl = 1'b0;
   int   prev_cond = 0;

   always #2.5 clk = ~clk;

   thr_trigger_top u_thr_trigger_top (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cond_sel(cond_sel),
      .thr_low(thr_low), .thr_high(thr_high), .sample(sample),
      .sample_vld(sample_vld), .trig_level(trig_level), .trig_pulse(trig_pulse)
   );

   function automatic logic model(input int m, input logic cur, input int s, input int lo, input int hi);
      case (m)
         0: return s < lo;
         1: return s > hi;
         2: return (s >= lo) && (s <= hi);
         3: return cur ? !(s < lo) : (s > hi);
         4: return cur ? !(s > hi) : (s < lo);
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic act, input logic exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b (cond %0d sample %0d lo %0d hi %0d)",
                  req, what, act, exp, cond_sel, sample, thr_low, thr_high);
      end
   endtask

   // One clock with the given inputs; expected values computed from the requirements.
   task automatic step(input logic en, input int m, input int lo, input int hi,
                       input int s, input logic v, input string req);
      logic nl, np;
      @(negedge clk);
      enable = en; cond_sel = m[2:0]; thr_low = lo[7:0]; thr_high = hi[7:0];
      sample = s[7:0]; sample_vld = v;
      @(posedge clk);
      if (!en || m != prev_cond) nl = 1'b0;
      else if (v)                nl = model(m, exp_lvl, s, lo, hi);
      else                       nl = exp_lvl;
      np = nl & ~exp_lvl;
      exp_lvl = nl;
      prev_cond = m;
      #1;
      check(req, trig_level, exp_lvl, "level");
      check("R10", trig_pulse, np, "pulse");
   endtask

   function automatic string tag(input int m);
      case (m)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R6";
         default: return "R1";
      endcase
   endfunction

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int los[4] = '{8'h40, 8'h00, 8'h80, 8'hC0};
      int his[4] = '{8'hC0, 8'hFF, 8'h80, 8'h20};
      // R11: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R11", trig_level, 1'b0, "reset level");
      check("R11", trig_pulse, 1'b0, "reset pulse");
      @(negedge clk);
      rst_n = 1'b1;
      prev_cond = 0;
      exp_lvl = 1'b0;

      // Sweeps: every condition, several threshold pairs, ramp up then down.
      for (int m = 0; m < 8; m++) begin
         for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 512; i++) begin
               int s = (i < 256) ? i : 511 - i;
               logic v = (i % 7) != 3;
               step(1'b1, m, los[p], his[p], s, v, v ? tag(m) : "R7");
            end
         end
      end

      // R3: low threshold ignored in mode 1
      for (int lo = 0; lo < 256; lo += 17) step(1'b1, 1, lo, 8'h50, 8'h90, 1'b1, "R3");

      // R8: enable low clears an asserted level
      step(1'b1, 1, 0, 8'h10, 8'hF0, 1'b1, "R3");
      step(1'b0, 1, 0, 8'h10, 8'hF0, 1'b1, "R8");
      step(1'b0, 1, 0, 8'h10, 8'hF0, 1'b0, "R8");
      step(1'b1, 1, 0, 8'h10, 8'hF0, 1'b1, "R8");

      // R9: condition change with a valid sample that would set the new condition
      step(1'b1, 0, 8'h30, 8'h60, 8'hA0, 1'b1, "R2");
      step(1'b1, 1, 8'h30, 8'h60, 8'hA0, 1'b1, "R9");
      step(1'b1, 1, 8'h30, 8'h60, 8'hA0, 1'b1, "R9");
      // R9: change clears hysteresis state mid-hold
      step(1'b1, 3, 8'h30, 8'h60, 8'h50, 1'b1, "R5");
      step(1'b1, 3, 8'h30, 8'h60, 8'h70, 1'b1, "R5");
      step(1'b1, 3, 8'h30, 8'h60, 8'h50, 1'b1, "R5");
      step(1'b1, 4, 8'h30, 8'h60, 8'h50, 1'b1, "R9");
      step(1'b1, 3, 8'h30, 8'h60, 8'h50, 1'b1, "R9");
      step(1'b1, 3, 8'h30, 8'h60, 8'h50, 1'b1, "R5");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule